// File: doc/BRIEF.md
# Full-Bridge Commutation Gate Controller

This block drives the four gate-enable lines of an H-bridge: upper-left, upper-right, lower-left and lower-right. It takes a supply-good flag that has already been qualified for undervoltage, a release input for delayed start, a divider-off select, an asynchronous stop input and a commutation clock. The commutation clock may come from an outside source or from an on-chip oscillator. From these inputs it produces one of four output patterns: precharge, all-off, or one of the two diagonals.

The controller has two commutation modes.
- **Halving mode:** the bridge flips diagonal on every falling edge of the commutation clock. This gives an exact 50% duty cycle at half the clock rate.
- **Direct mode:** the active diagonal follows the clock level.

Every change of diagonal, and every entry into conduction, passes through a gap in which all four switches are off. The gap lasts a parameterised number of system-clock cycles. The stop input forces every gate low combinationally, so it takes effect before any synchronizer settles.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: Only two conducting patterns exist. Written as {hl,hr,ll,lr}, diagonal A is 1001 and diagonal B is 0110. No leg ever has its upper and lower switch high together.
- R2: In reset, and whenever supply-good is low or start-release is low (with stop inactive), the outputs show the precharge pattern 0011: both lower switches on, both upper switches off.
- R3: While stop_i is high, all four outputs are 0 in the same instant, with no clock edge needed. This also holds while the supply is missing.
- R4: In halving mode (div_off_i = 0), the diagonal flips once per falling edge of comm_clk_i. Rising edges cause no change.
- R5: In halving mode, the first conducting pattern after precharge or stop is always diagonal A (1001), whatever the clock level and whatever the diagonal before.
- R6: In direct mode (div_off_i = 1), a high comm_clk_i level selects diagonal A and a low level selects diagonal B. This applies both while running and on entry.
- R7: Every change of diagonal, and every exit from precharge, contains exactly DEAD_CYC system-clock cycles with all outputs 0. The default is 4 cycles, i.e. 20 ns at 200 MHz.
- R8: If supply-good falls while the bridge conducts, the outputs return to precharge. When the supply comes back, the full entry sequence (gap, then diagonal A in halving mode) runs again.
- R9: A stop asserted in the middle of a gap cancels that countdown. After stop is released, the outputs stay low for SYNC_STAGES + DEAD_CYC cycles (the synchronizer delay plus a fresh gap) before conducting.
- R10: Each control input passes through SYNC_STAGES flops plus the state register. A change on supply_ok_i reaches the outputs at the (SYNC_STAGES+1)-th rising edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply qualified above undervoltage threshold |
| start_rel_i | input | 1 | Delayed-start release; low holds precharge |
| div_off_i | input | 1 | 1 = direct mode, 0 = halving mode |
| stop_i | input | 1 | Asynchronous stop, forces every gate low |
| comm_clk_i | input | 1 | Commutation clock |
| gate_hl_o | output | 1 | Upper-left gate enable |
| gate_hr_o | output | 1 | Upper-right gate enable |
| gate_ll_o | output | 1 | Lower-left gate enable |
| gate_lr_o | output | 1 | Lower-right gate enable |

## Verification
The bench builds the block with its defaults: DEAD_CYC = 4 and SYNC_STAGES = 2. At these values an input change reaches the outputs three edges later, and a gap lasts four cycles. The bench can therefore count individual cycles and distinguish a gap that is one cycle too short or too long. It can also catch a synchronizer with a missing or extra stage. A commutation clock period of 16 system cycles leaves room for latency, gap and a steady diagonal within each half period. That is enough to observe ignored rising edges, and a stop applied mid-gap.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

    typedef enum logic [1:0] {
        PH_PRECHARGE = 2'd0,
        PH_OFF       = 2'd1,
        PH_GAP       = 2'd2,
        PH_DRIVE     = 2'd3
    } phase_t;

    // diagonal select: 1 = upper-left + lower-right, 0 = upper-right + lower-left
    localparam logic DIAG_A = 1'b1;

endpackage

// File: rtl/hbc_sync.sv
module hbc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign stg_d[i] = din;
        end else begin : g_next
            assign stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/hbc_core.sv
module hbc_core
    import hbc_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ok_s,
    input  logic   rel_s,
    input  logic   div_off_s,
    input  logic   halt_s,
    input  logic   comm_s,
    output phase_t phase_o,
    output logic   diag_o
);
    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] GAP_LOAD = CW'(DEAD_CYC - 1);

    typedef struct packed {
        phase_t        phase;
        logic          diag;
        logic          tgt;
        logic          clk_prev;
        logic [CW-1:0] cnt;
    } core_st_t;

    localparam core_st_t RST_ST = '{phase: PH_PRECHARGE, diag: DIAG_A,
                                    tgt: DIAG_A, clk_prev: 1'b0, cnt: '0};

    core_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = comm_s;
        if (halt_s) begin
            st_d.phase = PH_OFF;
            st_d.cnt   = '0;
        end else if (!ok_s || !rel_s) begin
            st_d.phase = PH_PRECHARGE;
            st_d.cnt   = '0;
        end else begin
            case (st_q.phase)
                PH_PRECHARGE, PH_OFF: begin
                    st_d.phase = PH_GAP;
                    st_d.cnt   = GAP_LOAD;
                    st_d.tgt   = div_off_s ? comm_s : DIAG_A;
                end
                PH_DRIVE: begin
                    if (!div_off_s) begin
                        if (st_q.clk_prev && !comm_s) begin
                            st_d.phase = PH_GAP;
                            st_d.cnt   = GAP_LOAD;
                            st_d.tgt   = ~st_q.diag;
                        end
                    end else if (comm_s != st_q.diag) begin
                        st_d.phase = PH_GAP;
                        st_d.cnt   = GAP_LOAD;
                        st_d.tgt   = comm_s;
                    end
                end
                PH_GAP: begin
                    if (st_q.cnt == '0) begin
                        st_d.phase = PH_DRIVE;
                        st_d.diag  = st_q.tgt;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                default: st_d.phase = PH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign phase_o = st_q.phase;
    assign diag_o  = st_q.diag;

    // R7
    gap_before_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DRIVE && $past(st_q.phase) != PH_DRIVE)
        |-> ($past(st_q.phase) == PH_GAP && $past(st_q.cnt) == '0));

    // R7
    gap_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_GAP) |-> (st_q.cnt <= GAP_LOAD));

    // R5
    halving_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_GAP && ($past(st_q.phase) == PH_PRECHARGE ||
         $past(st_q.phase) == PH_OFF) && !$past(div_off_s))
        |-> (st_q.tgt == DIAG_A));

    // R8
    precharge_on_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ok_s && !halt_s) |=> (st_q.phase == PH_PRECHARGE));
endmodule

// File: rtl/hbc_gate_decode.sv
module hbc_gate_decode
    import hbc_pkg::*;
(
    input  phase_t phase,
    input  logic   diag,
    input  logic   halt_raw,
    output logic   hl,
    output logic   hr,
    output logic   ll,
    output logic   lr
);
    logic drv, pre;

    always_comb begin
        drv = (phase == PH_DRIVE);
        pre = (phase == PH_PRECHARGE);
        hl  = ~halt_raw & drv &  diag;
        lr  = ~halt_raw & ((drv & diag) | pre);
        hr  = ~halt_raw & drv & ~diag;
        ll  = ~halt_raw & ((drv & ~diag) | pre);
    end
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
    import hbc_pkg::*;
#(
    parameter int DEAD_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic start_rel_i,
    input  logic div_off_i,
    input  logic stop_i,
    input  logic comm_clk_i,
    output logic gate_hl_o,
    output logic gate_hr_o,
    output logic gate_ll_o,
    output logic gate_lr_o
);
    localparam int NIN = 5;

    logic [NIN-1:0] raw_in, sync_out;
    phase_t         phase;
    logic           diag;

    assign raw_in = {stop_i, supply_ok_i, start_rel_i, div_off_i, comm_clk_i};

    hbc_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_out)
    );

    hbc_core #(.DEAD_CYC(DEAD_CYC)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ok_s     (sync_out[3]),
        .rel_s    (sync_out[2]),
        .div_off_s(sync_out[1]),
        .halt_s   (sync_out[4]),
        .comm_s   (sync_out[0]),
        .phase_o  (phase),
        .diag_o   (diag)
    );

    hbc_gate_decode u_dec (
        .phase   (phase),
        .diag    (diag),
        .halt_raw(stop_i),
        .hl      (gate_hl_o),
        .hr      (gate_hr_o),
        .ll      (gate_ll_o),
        .lr      (gate_lr_o)
    );

    // R1
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hl_o && gate_ll_o) && !(gate_hr_o && gate_lr_o));

    // R3
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |-> !(gate_hl_o || gate_hr_o || gate_ll_o || gate_lr_o));
endmodule

// File: tb/hbridge_gate_ctrl_test.sv
module hbridge_gate_ctrl_test;
    localparam logic [3:0] PAT_A   = 4'b1001;
    localparam logic [3:0] PAT_B   = 4'b0110;
    localparam logic [3:0] PAT_PRE = 4'b0011;
    localparam logic [3:0] PAT_OFF = 4'b0000;
    localparam int DEAD = 4;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok_i = 1'b0, start_rel_i = 1'b0, div_off_i = 1'b0;
    logic stop_i = 1'b0, comm_clk_i = 1'b0;
    logic gate_hl_o, gate_hr_o, gate_ll_o, gate_lr_o;
    logic [3:0] g;
    int n_chk = 0, n_bad = 0, conflicts = 0, odd_pats = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hbridge_gate_ctrl #(.DEAD_CYC(DEAD), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok_i),
        .start_rel_i(start_rel_i), .div_off_i(div_off_i), .stop_i(stop_i),
        .comm_clk_i(comm_clk_i), .gate_hl_o(gate_hl_o), .gate_hr_o(gate_hr_o),
        .gate_ll_o(gate_ll_o), .gate_lr_o(gate_lr_o)
    );

    assign g = {gate_hl_o, gate_hr_o, gate_ll_o, gate_lr_o};

    // R1 monitor
    always @(negedge clk) begin
        if ((g[3] && g[1]) || (g[2] && g[0])) conflicts++;
        if (!(g == PAT_A || g == PAT_B || g == PAT_PRE || g == PAT_OFF)) odd_pats++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic watch(input bit skip, input logic [3:0] old,
                         output int lows, output logic [3:0] pat);
        int guard = 0;
        lows = 0;
        @(negedge clk);
        if (skip)
            while (g == old && guard < 200) begin guard++; @(negedge clk); end
        while (g == PAT_OFF && guard < 200) begin lows++; guard++; @(negedge clk); end
        pat = g;
    endtask

    task automatic t_reset;
        tick(2);
        check("R2 pattern in reset", g, PAT_PRE);
        rst_n = 1'b1;
        tick(6);
        check("R2 pattern after reset, supply low", g, PAT_PRE);
    endtask

    task automatic t_precharge_hold;
        supply_ok_i = 1'b1; start_rel_i = 1'b0;
        tick(6);
        check("R2 release low holds precharge", g, PAT_PRE);
        supply_ok_i = 1'b0; start_rel_i = 1'b1;
        tick(6);
        check("R2 supply low holds precharge", g, PAT_PRE);
    endtask

    task automatic t_halving_entry;
        int lows; logic [3:0] pat;
        div_off_i = 1'b0; comm_clk_i = 1'b0;
        tick(4);
        supply_ok_i = 1'b1;
        watch(1'b1, PAT_PRE, lows, pat);
        check("R7 gap on leaving precharge", lows, DEAD);
        check("R5 halving entry diagonal", pat, PAT_A);
    endtask

    task automatic t_halving_toggle;
        int lows; logic [3:0] pat;
        comm_clk_i = 1'b1;
        tick(10);
        check("R4 rising edge ignored", g, PAT_A);
        comm_clk_i = 1'b0;
        watch(1'b1, PAT_A, lows, pat);
        check("R7 gap on diagonal flip", lows, DEAD);
        check("R4 falling edge flips to B", pat, PAT_B);
        comm_clk_i = 1'b1;
        tick(10);
        check("R4 second rising edge ignored", g, PAT_B);
        comm_clk_i = 1'b0;
        watch(1'b1, PAT_B, lows, pat);
        check("R4 falling edge flips back to A", pat, PAT_A);
        comm_clk_i = 1'b1; tick(8);
        comm_clk_i = 1'b0; tick(12);
        check("R4 third fall gives B", g, PAT_B);
    endtask

    task automatic t_stop;
        int lows; logic [3:0] pat;
        stop_i = 1'b1;
        #1;
        check("R3 stop forces all low at once", g, PAT_OFF);
        tick(8);
        check("R3 stop held", g, PAT_OFF);
        supply_ok_i = 1'b0;
        tick(8);
        check("R3 stop overrides precharge", g, PAT_OFF);
        supply_ok_i = 1'b1;
        tick(8);
        stop_i = 1'b0;
        watch(1'b0, PAT_OFF, lows, pat);
        check("R9 low span after stop release", lows, SYNC + DEAD);
        check("R5 halving resumes on A after stop", pat, PAT_A);
    endtask

    task automatic t_abort;
        int lows; logic [3:0] pat; int guard = 0;
        comm_clk_i = 1'b1; tick(8);
        comm_clk_i = 1'b0;
        while (g != PAT_OFF && guard < 50) begin guard++; @(negedge clk); end
        @(negedge clk);
        stop_i = 1'b1;
        tick(5);
        stop_i = 1'b0;
        watch(1'b0, PAT_OFF, lows, pat);
        check("R9 mid-gap stop restarts full gap", lows, SYNC + DEAD);
        check("R9 resumes on A after aborted flip", pat, PAT_A);
    endtask

    task automatic t_supply_drop;
        int lows; logic [3:0] pat;
        comm_clk_i = 1'b1; tick(8);
        comm_clk_i = 1'b0; tick(12);
        check("R8 running on B before drop", g, PAT_B);
        supply_ok_i = 1'b0;
        tick(1);
        check("R10 no change after 1 edge", g, PAT_B);
        tick(1);
        check("R10 no change after 2 edges", g, PAT_B);
        tick(1);
        check("R10 precharge at 3rd edge", g, PAT_PRE);
        tick(4);
        supply_ok_i = 1'b1;
        watch(1'b1, PAT_PRE, lows, pat);
        check("R8 full entry gap after recovery", lows, DEAD);
        check("R8 recovery starts on A", pat, PAT_A);
    endtask

    task automatic t_direct;
        int lows; logic [3:0] pat;
        comm_clk_i = 1'b1;
        div_off_i  = 1'b1;
        tick(10);
        check("R6 high level holds A", g, PAT_A);
        comm_clk_i = 1'b0;
        watch(1'b1, PAT_A, lows, pat);
        check("R7 direct-mode gap", lows, DEAD);
        check("R6 low level selects B", pat, PAT_B);
        comm_clk_i = 1'b1;
        watch(1'b1, PAT_B, lows, pat);
        check("R6 high level selects A", pat, PAT_A);
        comm_clk_i = 1'b0;
        stop_i = 1'b1; tick(8);
        stop_i = 1'b0;
        watch(1'b0, PAT_OFF, lows, pat);
        check("R6 direct entry follows low level", pat, PAT_B);
    endtask

    initial begin
        #500us;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_precharge_hold();
        t_halving_entry();
        t_halving_toggle();
        t_stop();
        t_abort();
        t_supply_drop();
        t_direct();
        check("R1 leg conflicts seen", conflicts, 0);
        check("R1 patterns outside allowed set", odd_pats, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule